// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Drive Sequencer

This block generates the time-multiplexed drive pattern for a passive LCD panel with 28 segment lines and up to four common lines. It supports up to 14 digits. A frame tick from an external divider advances the active common phase. The display memory holds one bit per segment and common pair, and segment `s` paired with common `c` sits at bit index `s*4+c`. The block turns the tick and the display memory into one 2-bit ladder index per pin. A later analog stage maps each index onto a voltage: code 0 is the ground rail and code 3 is the top rail. Codes 1 and 2 are the intermediate taps.

Four duty modes are selected by a 2-bit field: 0 is static, 1 is 1/2 duty, 2 is 1/3 duty and 3 is 1/4 duty. The duty is the mode value plus one. Each mode has its bias. Static has no intermediate level. 1/2 duty uses 1/2 bias, and 1/4 duty uses 1/3 bias. 1/3 duty takes 1/2 or 1/3 bias from a configuration bit. The drive polarity flips at the end of every full scan of the commons, so no pixel carries a DC component.

Any group of four adjacent segment pins can be switched away from the display and used as plain output bits.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset `phase_o` is 0 and `frame_pol_o` is 0. With `en_i` low, every common output and every non-bypassed segment output is code 0.
- R2: While enabled, each `tick_i` cycle advances `phase_o` by one. When `phase_o` is at or above `mode_i` (duty minus one), the tick returns it to 0. Without a tick, `phase_o` holds its value.
- R3: `frame_pol_o` toggles exactly when the phase wraps to 0. In static mode this is every tick. It never changes otherwise.
- R4: Driving `en_i` low forces every common and every non-bypassed segment to code 0 in the same cycle. It also clears `phase_o` and `frame_pol_o` at the next clock edge, and ticks are then ignored.
- R5: The common whose index equals `phase_o` and does not exceed `mode_i` is selected. A selected common outputs code 3 at polarity 0 and code 0 at polarity 1. Every other common outputs the unselected level for the active bias: code 1 under 1/2 bias, and code 1 at polarity 0 or code 2 at polarity 1 under 1/3 bias.
- R6: Commons above the duty, and the common named by a phase left beyond the duty, are never selected. In static mode they output code 0. Otherwise they output the unselected level from R5.
- R7: Segment `s` reads display bit `s*4+phase_o`. A lit pixel outputs code 0 at polarity 0 and code 3 at polarity 1. An unlit pixel outputs the same code as the selected common in static mode, code 1 under 1/2 bias, and code 2 at polarity 0 or code 1 at polarity 1 under 1/3 bias.
- R8: 1/2 duty always uses 1/2 bias and 1/4 duty always uses 1/3 bias. In 1/3 duty, `bias_third_i`=1 selects 1/3 bias and 0 selects 1/2 bias. `bias_third_i` has no effect in the other modes.
- R9: When `gpo_sel_i[g]` is 1, segments `4g` to `4g+3` output code 3 for a 1 in the matching `gpo_val_i` bit and code 0 for a 0. This holds regardless of `en_i`, phase and polarity.
- R10: If `mode_i` shrinks while `phase_o` is beyond the new duty, `phase_o` holds with no common selected. The next tick wraps it to 0 and toggles `frame_pol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Display enable; low blanks the panel and parks the scan |
| tick_i | input | 1 | One-cycle pulse that advances the common phase |
| mode_i | input | 2 | Duty mode: 0 static, 1 half, 2 third, 3 quarter |
| bias_third_i | input | 1 | In 1/3 duty: 1 gives 1/3 bias, 0 gives 1/2 bias |
| pix_i | input | 112 | Display bits, segment s and common c at bit s*4+c |
| gpo_sel_i | input | 7 | Per group of four segments: 1 turns the pins into plain outputs |
| gpo_val_i | input | 28 | Plain output values for bypassed segment pins |
| com_lvl_o | output | 8 | Ladder index of common c at bits [2c+1:2c] |
| seg_lvl_o | output | 56 | Ladder index of segment s at bits [2s+1:2s] |
| phase_o | output | 2 | Current common phase |
| frame_pol_o | output | 1 | Current drive polarity |

## Verification
Two events can land in the same cycle: a frame tick that wraps the scan and flips polarity, and a change of the display bits, duty mode or bypass selection. The bench changes the display memory at every step of every mode and bias. It recomputes every pin code from the model's phase and polarity after each edge, so stale polarity or a pixel read from the old phase shows up as a mismatch. A mode shrink with the phase parked beyond the new duty is provoked on purpose. The bench judges that no common is selected until the following tick wraps and flips polarity. Dropping the enable in the middle of a frame is checked once before the edge, with outputs blank and state unchanged, and once after it, with state cleared.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_DUTY2  = 2'd1,
    MODE_DUTY3  = 2'd2,
    MODE_DUTY4  = 2'd3
  } lcd_mode_e;

  typedef enum logic [1:0] {
    BIAS_NONE  = 2'd0,
    BIAS_HALF  = 2'd1,
    BIAS_THIRD = 2'd2
  } lcd_bias_e;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_BOT = 2'd0;
  localparam lvl_t LVL_LO  = 2'd1;
  localparam lvl_t LVL_HI  = 2'd2;
  localparam lvl_t LVL_TOP = 2'd3;

  // extreme level driven on a selected common
  function automatic lvl_t sel_lvl(input logic pol);
    return pol ? LVL_BOT : LVL_TOP;
  endfunction

  // extreme level on a lit segment: opposite rail to the selected common
  function automatic lvl_t on_lvl(input logic pol);
    return pol ? LVL_TOP : LVL_BOT;
  endfunction

  // non-select level for commons (is_seg=0) or unlit segments (is_seg=1)
  function automatic lvl_t idle_lvl(input lcd_bias_e bias, input logic pol,
                                    input logic is_seg);
    lvl_t l;
    unique case (bias)
      BIAS_HALF:  l = LVL_LO;
      BIAS_THIRD: l = (pol ^ is_seg) ? LVL_HI : LVL_LO;
      default:    l = is_seg ? sel_lvl(pol) : LVL_BOT;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/lcd_phase_ctr.sv
module lcd_phase_ctr #(
  parameter  int NUM_COM = 4,
  localparam int PW      = $clog2(NUM_COM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [PW-1:0] last_i,
  output logic [PW-1:0] phase_o,
  output logic          pol_o
);
  logic [PW-1:0] phase_q;
  logic          pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pol_q   <= 1'b0;
    end else if (!en_i) begin
      phase_q <= '0;
      pol_q   <= 1'b0;
    end else if (tick_i) begin
      // >= so a phase stranded by a mode shrink recovers on the next tick
      if (phase_q >= last_i) begin
        phase_q <= '0;
        pol_q   <= ~pol_q;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign pol_o   = pol_q;
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_mux_pkg::*;
#(
  parameter  int NUM_COM = 4,
  localparam int PW      = $clog2(NUM_COM)
) (
  input  logic                 en_i,
  input  lcd_bias_e            bias_i,
  input  logic                 pol_i,
  input  logic [PW-1:0]        phase_i,
  input  logic [PW-1:0]        last_i,
  output logic [2*NUM_COM-1:0] com_lvl_o
);
  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    localparam logic [PW-1:0] IDX = PW'(c);
    logic sel;
    lvl_t lvl;
    assign sel = (phase_i == IDX) && (IDX <= last_i);
    always_comb begin
      if (!en_i)    lvl = LVL_BOT;
      else if (sel) lvl = sel_lvl(pol_i);
      else          lvl = idle_lvl(bias_i, pol_i, 1'b0);
    end
    assign com_lvl_o[2*c +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_mux_pkg::*;
#(
  parameter  int NUM_SEG = 28,
  parameter  int NUM_COM = 4,
  parameter  int GRP     = 4,
  localparam int PW      = $clog2(NUM_COM),
  localparam int NUM_GRP = NUM_SEG / GRP
) (
  input  logic                       en_i,
  input  lcd_bias_e                  bias_i,
  input  logic                       pol_i,
  input  logic [PW-1:0]              phase_i,
  input  logic [NUM_SEG*NUM_COM-1:0] pix_i,
  input  logic [NUM_GRP-1:0]         gpo_sel_i,
  input  logic [NUM_SEG-1:0]         gpo_val_i,
  output logic [2*NUM_SEG-1:0]       seg_lvl_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar k = 0; k < GRP; k++) begin : g_pin
      localparam int S = g*GRP + k;
      logic [NUM_COM-1:0] col;
      logic on;
      lvl_t lvl;
      assign col = pix_i[S*NUM_COM +: NUM_COM];
      assign on  = col[phase_i];
      always_comb begin
        if (gpo_sel_i[g]) lvl = gpo_val_i[S] ? LVL_TOP : LVL_BOT;
        else if (!en_i)   lvl = LVL_BOT;
        else if (on)      lvl = on_lvl(pol_i);
        else              lvl = idle_lvl(bias_i, pol_i, 1'b1);
      end
      assign seg_lvl_o[2*S +: 2] = lvl;
    end
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_mux_pkg::*;
#(
  parameter  int NUM_SEG = 28,
  parameter  int NUM_COM = 4,
  parameter  int GRP     = 4,
  localparam int PW      = $clog2(NUM_COM),
  localparam int NUM_GRP = NUM_SEG / GRP
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       tick_i,
  input  logic [1:0]                 mode_i,
  input  logic                       bias_third_i,
  input  logic [NUM_SEG*NUM_COM-1:0] pix_i,
  input  logic [NUM_GRP-1:0]         gpo_sel_i,
  input  logic [NUM_SEG-1:0]         gpo_val_i,
  output logic [2*NUM_COM-1:0]       com_lvl_o,
  output logic [2*NUM_SEG-1:0]       seg_lvl_o,
  output logic [PW-1:0]              phase_o,
  output logic                       frame_pol_o
);
  lcd_bias_e     bias;
  logic [PW-1:0] last;
  logic [PW-1:0] phase;
  logic          pol;

  assign last = PW'(mode_i);

  always_comb begin
    unique case (lcd_mode_e'(mode_i))
      MODE_DUTY2: bias = BIAS_HALF;
      MODE_DUTY3: bias = bias_third_i ? BIAS_THIRD : BIAS_HALF;
      MODE_DUTY4: bias = BIAS_THIRD;
      default:    bias = BIAS_NONE;
    endcase
  end

  lcd_phase_ctr #(.NUM_COM(NUM_COM)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick_i),
    .last_i  (last),
    .phase_o (phase),
    .pol_o   (pol)
  );

  lcd_com_drv #(.NUM_COM(NUM_COM)) u_com (
    .en_i      (en_i),
    .bias_i    (bias),
    .pol_i     (pol),
    .phase_i   (phase),
    .last_i    (last),
    .com_lvl_o (com_lvl_o)
  );

  lcd_seg_drv #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .GRP(GRP)) u_seg (
    .en_i      (en_i),
    .bias_i    (bias),
    .pol_i     (pol),
    .phase_i   (phase),
    .pix_i     (pix_i),
    .gpo_sel_i (gpo_sel_i),
    .gpo_val_i (gpo_val_i),
    .seg_lvl_o (seg_lvl_o)
  );

  assign phase_o     = phase;
  assign frame_pol_o = pol;
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter  int NUM_SEG = 28,
  parameter  int NUM_COM = 4,
  parameter  int GRP     = 4,
  localparam int PW      = $clog2(NUM_COM),
  localparam int NUM_GRP = NUM_SEG / GRP
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       en_i,
  input logic                       tick_i,
  input logic [1:0]                 mode_i,
  input logic                       bias_third_i,
  input logic [NUM_SEG*NUM_COM-1:0] pix_i,
  input logic [NUM_GRP-1:0]         gpo_sel_i,
  input logic [NUM_SEG-1:0]         gpo_val_i,
  input logic [2*NUM_COM-1:0]       com_lvl_o,
  input logic [2*NUM_SEG-1:0]       seg_lvl_o,
  input logic [PW-1:0]              phase_o,
  input logic                       frame_pol_o
);
  logic [NUM_COM-1:0] com_top;
  for (genvar c = 0; c < NUM_COM; c++) begin : g_top
    assign com_top[c] = (com_lvl_o[2*c +: 2] == 2'd3);
  end

  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && (phase_o < PW'(mode_i))) |=> (phase_o == $past(phase_o) + 1'b1));

  assert_wrap_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && (phase_o >= PW'(mode_i))) |=>
      (phase_o == '0) && (frame_pol_o != $past(frame_pol_o)));

  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(phase_o) && $stable(frame_pol_o)));

  assert_disable_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_o == '0) && !frame_pol_o);

  assert_disable_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (com_lvl_o == '0));

  assert_single_select_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frame_pol_o) |-> $onehot0(com_top));

  assert_gpo_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpo_sel_i[0] |-> (seg_lvl_o[1:0] == {2{gpo_val_i[0]}}));
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(
  .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .GRP(GRP)
) u_chk (.*);

// File: tb/tb_lcd_mux_seq.sv
module tb_lcd_mux_seq;
  localparam int NS = 28;
  localparam int NC = 4;
  localparam int NG = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic tick = 1'b0;
  logic bt = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [NS*NC-1:0] pix = '0;
  logic [NG-1:0] gsel = '0;
  logic [NS-1:0] gval = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;
  logic [1:0] phase;
  logic pol;

  int errors = 0;
  int checks = 0;
  int m_phase = 0;
  logic m_pol = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  lcd_mux_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .mode_i(mode),
    .bias_third_i(bt), .pix_i(pix), .gpo_sel_i(gsel), .gpo_val_i(gval),
    .com_lvl_o(com_lvl), .seg_lvl_o(seg_lvl), .phase_o(phase), .frame_pol_o(pol)
  );

  function automatic logic is_third();
    return (mode == 2'd3) || ((mode == 2'd2) && bt);
  endfunction

  // R5 R6 R8 model
  function automatic logic [1:0] exp_com(int c);
    if (!en) return 2'd0;
    if (c == m_phase && c <= int'(mode)) return m_pol ? 2'd0 : 2'd3;
    if (mode == 2'd0) return 2'd0;
    if (!is_third()) return 2'd1;
    return m_pol ? 2'd2 : 2'd1;
  endfunction

  // R7 R8 R9 model
  function automatic logic [1:0] exp_seg(int s);
    if (gsel[s/4]) return gval[s] ? 2'd3 : 2'd0;
    if (!en) return 2'd0;
    if (pix[s*4 + m_phase]) return m_pol ? 2'd3 : 2'd0;
    if (mode == 2'd0) return m_pol ? 2'd0 : 2'd3;
    if (!is_third()) return 2'd1;
    return m_pol ? 2'd1 : 2'd2;
  endfunction

  task automatic shuffle_pix();
    for (int i = 0; i < NS*NC; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      pix[i] = seed[16];
    end
  endtask

  task automatic chk(string tag);
    logic [2*NC-1:0] ec;
    logic [2*NS-1:0] es;
    #2;
    for (int c = 0; c < NC; c++) ec[2*c +: 2] = exp_com(c);
    for (int s = 0; s < NS; s++) es[2*s +: 2] = exp_seg(s);
    checks++;
    if (phase !== m_phase[1:0] || pol !== m_pol) begin
      errors++;
      $display("FAIL %s phase/pol got %0d/%0d exp %0d/%0d", tag, phase, pol, m_phase, m_pol);
    end
    checks++;
    if (com_lvl !== ec) begin
      errors++;
      $display("FAIL %s com got %h exp %h (mode %0d bt %0d)", tag, com_lvl, ec, mode, bt);
    end
    checks++;
    if (seg_lvl !== es) begin
      errors++;
      $display("FAIL %s seg got %h exp %h (mode %0d bt %0d)", tag, seg_lvl, es, mode, bt);
    end
  endtask

  // R2 R3 model update
  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (en) begin
      if (m_phase >= int'(mode)) begin
        m_phase = 0;
        m_pol = ~m_pol;
      end else begin
        m_phase++;
      end
    end
  endtask

  task automatic restart(logic [1:0] md, logic b);
    @(negedge clk) begin en = 1'b0; mode = md; bt = b; end
    @(negedge clk) begin m_phase = 0; m_pol = 1'b0; en = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R2 scan hung)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle");

    // sweep every mode and bias bit over two full frames, R2 R3 R5 R6 R7 R8
    for (int md = 0; md < 4; md++) begin
      for (int b = 0; b < 2; b++) begin
        restart(2'(md), 1'(b));
        for (int st = 0; st <= 2*(md+1); st++) begin
          shuffle_pix();
          chk("R2/R3/R5/R6/R7/R8 sweep");
          do_tick();
        end
      end
    end

    // all-on and all-off panels under 1/3 duty with 1/3 bias, R7
    restart(2'd2, 1'b1);
    for (int st = 0; st < 6; st++) begin
      pix = (st < 3) ? '1 : '0;
      chk("R7 uniform");
      do_tick();
    end

    // disable mid-frame, R4
    restart(2'd3, 1'b0);
    do_tick();
    do_tick();
    @(negedge clk) en = 1'b0;
    chk("R4 blank before edge");
    @(negedge clk) begin m_phase = 0; m_pol = 1'b0; end
    chk("R4 cleared");
    do_tick();
    chk("R4 tick ignored");

    // mode shrink with stranded phase, R10
    restart(2'd3, 1'b0);
    do_tick(); do_tick(); do_tick();
    chk("R10 phase 3");
    @(negedge clk) mode = 2'd1;
    chk("R10 stranded");
    do_tick();
    chk("R10 wrapped");
    do_tick();
    chk("R10 resumed");

    // bypass groups, R9
    restart(2'd3, 1'b1);
    gsel = 7'b1000101;
    gval = 28'hA5C_3F19;
    shuffle_pix();
    chk("R9 enabled");
    do_tick();
    chk("R9 after tick");
    @(negedge clk) en = 1'b0;
    chk("R9 disabled");
    @(negedge clk) begin m_phase = 0; m_pol = 1'b0; gval = ~gval; end
    chk("R9 toggled");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule